// File: doc/BRIEF.md
# Functional Unit Recomputation Checker

This block sits at the retirement end of a speculative core. Completed instructions arrive in program order, one per cycle. Each one carries its opcode, its tag, the input operands the core used, an immediate, its program counter and the result the core computed. The checker works out the result a second time with a small, separate datapath. It then compares that value with the core's result and raises a mismatch flag. The recomputed value always leaves the block as the correction.

There are two stages. The recompute stage evaluates the operation from the supplied inputs and latches the result. The compare stage checks the latched value against the core result and presents the verdict. Every instruction brings its own inputs, so instructions never depend on one another. The pipeline therefore has no bypass, never stalls and has no backpressure. Each stage owns a slot controller with two states, SLOT_EMPTY and SLOT_FULL. The transitions are FILL (empty to full when an instruction enters), KEEP (full to full), DRAIN (full to empty when no instruction enters) and FLUSH (any state to empty while flush is high). A side input tells the block that another check on the same instruction has failed; in that case the correction is marked untrusted.

Top module: `frc_top`

## Requirements
- R1: An instruction accepted with in_valid high in cycle k appears with out_valid high, at a rate of one instruction per cycle, in cycle k+2 (after two rising edges), with out_tag equal to its in_tag.
- R2: ALU opcodes (4-bit in_op) recompute as follows: 0 add a+b, 1 subtract a-b, 2 and, 3 or, 4 xor, 5 signed set-less-than (1 or 0), 6 shift left logical, 7 shift right logical and 8 shift right arithmetic. Every shift uses only the low log2(DATA_W) bits of src_b as the shift amount.
- R3: Opcode 9 (address generation) recomputes the effective address as src_a + imm, with wraparound modulo 2^DATA_W.
- R4: Branch opcodes 10 (equal), 11 (not equal) and 12 (signed less than) compare src_a with src_b. The recomputed value is the next PC: pc + imm if the branch is taken, else pc + 4. This one value therefore checks both the outcome and the target.
- R5: Opcodes 13, 14 and 15 are undefined and recompute to zero.
- R6: out_mismatch is high exactly when the recomputed value differs from in_core_res. out_fix_value always carries the recomputed value.
- R7: out_fix_ok equals the inverse of the in_other_fault bit that entered with the instruction.
- R8: While flush is high at a rising edge, both stages are emptied and any instruction offered in that cycle is dropped. No output appears for any of them.
- R9: After reset, out_valid and out_mismatch are low.
- R10: out_mismatch is never high while out_valid is low, and a cycle with in_valid low yields no output two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties both stages and drops the incoming instruction |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_tag | input | TAG_W | Instruction tag |
| in_op | input | 4 | Operation code |
| in_src_a | input | DATA_W | First core-supplied operand |
| in_src_b | input | DATA_W | Second core-supplied operand |
| in_imm | input | DATA_W | Immediate (offset for address generation and branches) |
| in_pc | input | DATA_W | Instruction address |
| in_core_res | input | DATA_W | Result computed by the core |
| in_other_fault | input | 1 | Another check failed for this instruction |
| out_valid | output | 1 | Verdict present |
| out_tag | output | TAG_W | Tag of the checked instruction |
| out_mismatch | output | 1 | Core result disagrees with the recomputation |
| out_fix_value | output | DATA_W | Recomputed (corrected) value |
| out_fix_ok | output | 1 | The correction can be trusted |

## Verification
The bench builds the block with its default parameters: DATA_W of 32 and TAG_W of 6. With 32-bit operands the bench reaches the signed boundary 0x80000000, a shift by 31 taken from a shift field wider than five bits, carry-out wraparound on addition, and negative branch and address offsets. The six-bit tag lets each of the table vectors carry a distinct tag, so any misrouting between stages shows up. Tag wraparound is not reached.

// File: rtl/frc_pkg.sv
package frc_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLT  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_SRA  = 4'd8,
        OP_AGEN = 4'd9,
        OP_BEQ  = 4'd10,
        OP_BNE  = 4'd11,
        OP_BLT  = 4'd12
    } op_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;

endpackage

// File: rtl/frc_alu.sv
module frc_alu
    import frc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int INST_BYTES = 4
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] imm,
    input  logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] value
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]   sh_amt;
    logic              lt_signed;
    logic              eq;
    logic [DATA_W-1:0] pc_seq;
    logic [DATA_W-1:0] pc_jump;
    logic              taken;

    always_comb begin
        sh_amt    = src_b[SH_W-1:0];
        lt_signed = $signed(src_a) < $signed(src_b);
        eq        = (src_a == src_b);
        pc_seq    = pc + DATA_W'(INST_BYTES);
        pc_jump   = pc + imm;
        taken     = 1'b0;
        value     = '0;
        unique case (op)
            OP_ADD:  value = src_a + src_b;
            OP_SUB:  value = src_a - src_b;
            OP_AND:  value = src_a & src_b;
            OP_OR:   value = src_a | src_b;
            OP_XOR:  value = src_a ^ src_b;
            OP_SLT:  value = {{(DATA_W-1){1'b0}}, lt_signed};
            OP_SLL:  value = src_a << sh_amt;
            OP_SRL:  value = src_a >> sh_amt;
            OP_SRA:  value = $unsigned($signed(src_a) >>> sh_amt);
            OP_AGEN: value = src_a + imm;
            OP_BEQ: begin
                taken = eq;
                value = taken ? pc_jump : pc_seq;
            end
            OP_BNE: begin
                taken = !eq;
                value = taken ? pc_jump : pc_seq;
            end
            OP_BLT: begin
                taken = lt_signed;
                value = taken ? pc_jump : pc_seq;
            end
            default: value = '0;
        endcase
    end
endmodule

// File: rtl/frc_recompute_stage.sv
module frc_recompute_stage
    import frc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int TAG_W      = 6,
    parameter int INST_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [3:0]        in_op,
    input  logic [DATA_W-1:0] in_src_a,
    input  logic [DATA_W-1:0] in_src_b,
    input  logic [DATA_W-1:0] in_imm,
    input  logic [DATA_W-1:0] in_pc,
    input  logic [DATA_W-1:0] in_core_res,
    input  logic              in_other_fault,
    output logic              s1_valid,
    output logic [TAG_W-1:0]  s1_tag,
    output logic [DATA_W-1:0] s1_recomp,
    output logic [DATA_W-1:0] s1_core_res,
    output logic              s1_other_fault
);
    slot_e             state_q;
    slot_e             state_d;
    logic              load;
    logic [DATA_W-1:0] alu_value;

    frc_alu #(
        .DATA_W    (DATA_W),
        .INST_BYTES(INST_BYTES)
    ) u_alu (
        .op   (in_op),
        .src_a(in_src_a),
        .src_b(in_src_b),
        .imm  (in_imm),
        .pc   (in_pc),
        .value(alu_value)
    );

    always_comb begin
        load    = in_valid && !flush;
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: state_d = load ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL:  state_d = load ? SLOT_FULL : SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_tag         <= '0;
            s1_recomp      <= '0;
            s1_core_res    <= '0;
            s1_other_fault <= 1'b0;
        end else if (load) begin
            s1_tag         <= in_tag;
            s1_recomp      <= alu_value;
            s1_core_res    <= in_core_res;
            s1_other_fault <= in_other_fault;
        end
    end

    always_comb s1_valid = (state_q == SLOT_FULL);
endmodule

// File: rtl/frc_compare_stage.sv
module frc_compare_stage
    import frc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              s1_valid,
    input  logic [TAG_W-1:0]  s1_tag,
    input  logic [DATA_W-1:0] s1_recomp,
    input  logic [DATA_W-1:0] s1_core_res,
    input  logic              s1_other_fault,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic              out_mismatch,
    output logic [DATA_W-1:0] out_fix_value,
    output logic              out_fix_ok
);
    slot_e state_q;
    slot_e state_d;
    logic  load;
    logic  differ;
    logic  mm_q;

    always_comb begin
        load    = s1_valid && !flush;
        differ  = (s1_recomp != s1_core_res);
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: state_d = load ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL:  state_d = load ? SLOT_FULL : SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_tag       <= '0;
            mm_q          <= 1'b0;
            out_fix_value <= '0;
            out_fix_ok    <= 1'b0;
        end else if (load) begin
            out_tag       <= s1_tag;
            mm_q          <= differ;
            out_fix_value <= s1_recomp;
            out_fix_ok    <= !s1_other_fault;
        end
    end

    always_comb begin
        out_valid    = (state_q == SLOT_FULL);
        out_mismatch = out_valid && mm_q;
    end
endmodule

// File: rtl/frc_top.sv
module frc_top #(
    parameter int DATA_W     = 32,
    parameter int TAG_W      = 6,
    parameter int INST_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [3:0]        in_op,
    input  logic [DATA_W-1:0] in_src_a,
    input  logic [DATA_W-1:0] in_src_b,
    input  logic [DATA_W-1:0] in_imm,
    input  logic [DATA_W-1:0] in_pc,
    input  logic [DATA_W-1:0] in_core_res,
    input  logic              in_other_fault,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic              out_mismatch,
    output logic [DATA_W-1:0] out_fix_value,
    output logic              out_fix_ok
);
    logic              s1_valid;
    logic [TAG_W-1:0]  s1_tag;
    logic [DATA_W-1:0] s1_recomp;
    logic [DATA_W-1:0] s1_core_res;
    logic              s1_other_fault;

    frc_recompute_stage #(
        .DATA_W    (DATA_W),
        .TAG_W     (TAG_W),
        .INST_BYTES(INST_BYTES)
    ) u_recompute (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .in_valid      (in_valid),
        .in_tag        (in_tag),
        .in_op         (in_op),
        .in_src_a      (in_src_a),
        .in_src_b      (in_src_b),
        .in_imm        (in_imm),
        .in_pc         (in_pc),
        .in_core_res   (in_core_res),
        .in_other_fault(in_other_fault),
        .s1_valid      (s1_valid),
        .s1_tag        (s1_tag),
        .s1_recomp     (s1_recomp),
        .s1_core_res   (s1_core_res),
        .s1_other_fault(s1_other_fault)
    );

    frc_compare_stage #(
        .DATA_W(DATA_W),
        .TAG_W (TAG_W)
    ) u_compare (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .s1_valid      (s1_valid),
        .s1_tag        (s1_tag),
        .s1_recomp     (s1_recomp),
        .s1_core_res   (s1_core_res),
        .s1_other_fault(s1_other_fault),
        .out_valid     (out_valid),
        .out_tag       (out_tag),
        .out_mismatch  (out_mismatch),
        .out_fix_value (out_fix_value),
        .out_fix_ok    (out_fix_ok)
    );
endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              in_valid,
    input logic [TAG_W-1:0]  in_tag,
    input logic              in_other_fault,
    input logic              out_valid,
    input logic [TAG_W-1:0]  out_tag,
    input logic              out_mismatch,
    input logic              out_fix_ok
);
    logic [1:0] up_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            up_cnt <= '0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    p_mismatch_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_mismatch |-> out_valid);

    p_latency_two_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2 && $past(in_valid, 2) && !$past(flush, 2) && !$past(flush, 1))
            |-> out_valid);

    p_tag_carried_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2 && out_valid) |-> out_tag == $past(in_tag, 2));

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd1 && $past(flush)) |-> !out_valid);

    p_trust_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2 && out_valid) |-> out_fix_ok == !$past(in_other_fault, 2));

    p_idle_no_output_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2 && !$past(in_valid, 2)) |-> !out_valid);
endmodule

bind frc_top frc_checker #(
    .DATA_W(DATA_W),
    .TAG_W (TAG_W)
) u_frc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .in_valid      (in_valid),
    .in_tag        (in_tag),
    .in_other_fault(in_other_fault),
    .out_valid     (out_valid),
    .out_tag       (out_tag),
    .out_mismatch  (out_mismatch),
    .out_fix_ok    (out_fix_ok)
);

// File: tb/test_frc_top.sv
module test_frc_top;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 6;
    localparam int NV     = 17;

    // {op, a, b, imm, pc, core_res, expected_value, expected_mismatch}
    localparam logic [196:0] VEC [NV] = '{
        {4'd0,  32'h00000005, 32'h00000007, 32'h0, 32'h0, 32'h0000000C, 32'h0000000C, 1'b0},
        {4'd0,  32'hFFFFFFFF, 32'h00000001, 32'h0, 32'h0, 32'h00000000, 32'h00000000, 1'b0},
        {4'd1,  32'h00000003, 32'h00000005, 32'h0, 32'h0, 32'hFFFFFFFE, 32'hFFFFFFFE, 1'b0},
        {4'd2,  32'hF0F0F0F0, 32'h0FF00FF0, 32'h0, 32'h0, 32'h00F000F1, 32'h00F000F0, 1'b1},
        {4'd3,  32'hF0000000, 32'h0000000F, 32'h0, 32'h0, 32'hF000000F, 32'hF000000F, 1'b0},
        {4'd4,  32'hAAAAAAAA, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h55555555, 32'h55555555, 1'b0},
        {4'd5,  32'hFFFFFFFF, 32'h00000001, 32'h0, 32'h0, 32'h00000000, 32'h00000001, 1'b1},
        {4'd5,  32'h00000005, 32'h00000005, 32'h0, 32'h0, 32'h00000000, 32'h00000000, 1'b0},
        {4'd6,  32'h00000001, 32'h0000003F, 32'h0, 32'h0, 32'h80000000, 32'h80000000, 1'b0},
        {4'd7,  32'h80000000, 32'h00000004, 32'h0, 32'h0, 32'h08000000, 32'h08000000, 1'b0},
        {4'd8,  32'h80000000, 32'h00000004, 32'h0, 32'h0, 32'h08000000, 32'hF8000000, 1'b1},
        {4'd9,  32'h00001000, 32'h0, 32'hFFFFFFFC, 32'h0, 32'h00000FFC, 32'h00000FFC, 1'b0},
        {4'd10, 32'h00000007, 32'h00000007, 32'h00000020, 32'h00000100, 32'h00000120, 32'h00000120, 1'b0},
        {4'd10, 32'h00000007, 32'h00000008, 32'h00000020, 32'h00000100, 32'h00000120, 32'h00000104, 1'b1},
        {4'd11, 32'h00000001, 32'h00000002, 32'hFFFFFFF0, 32'h00000200, 32'h000001F0, 32'h000001F0, 1'b0},
        {4'd12, 32'h80000000, 32'h00000000, 32'h00000008, 32'h00000300, 32'h00000304, 32'h00000308, 1'b1},
        {4'd15, 32'h00000001, 32'h00000002, 32'h0, 32'h0, 32'h00000005, 32'h00000000, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              in_valid = 1'b0;
    logic [TAG_W-1:0]  in_tag = '0;
    logic [3:0]        in_op = '0;
    logic [DATA_W-1:0] in_src_a = '0;
    logic [DATA_W-1:0] in_src_b = '0;
    logic [DATA_W-1:0] in_imm = '0;
    logic [DATA_W-1:0] in_pc = '0;
    logic [DATA_W-1:0] in_core_res = '0;
    logic              in_other_fault = 1'b0;
    logic              out_valid;
    logic [TAG_W-1:0]  out_tag;
    logic              out_mismatch;
    logic [DATA_W-1:0] out_fix_value;
    logic              out_fix_ok;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    frc_top #(.DATA_W(DATA_W), .TAG_W(TAG_W)) i_frc_top (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_tag(in_tag), .in_op(in_op), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_imm(in_imm), .in_pc(in_pc), .in_core_res(in_core_res),
        .in_other_fault(in_other_fault), .out_valid(out_valid), .out_tag(out_tag),
        .out_mismatch(out_mismatch), .out_fix_value(out_fix_value),
        .out_fix_ok(out_fix_ok)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive_vec(input int idx, input logic fl, input logic other);
        in_valid       = 1'b1;
        flush          = fl;
        in_tag         = TAG_W'(idx);
        in_op          = VEC[idx][196:193];
        in_src_a       = VEC[idx][192:161];
        in_src_b       = VEC[idx][160:129];
        in_imm         = VEC[idx][128:97];
        in_pc          = VEC[idx][96:65];
        in_core_res    = VEC[idx][64:33];
        in_other_fault = other;
    endtask

    task automatic idle();
        in_valid       = 1'b0;
        flush          = 1'b0;
        in_other_fault = 1'b0;
    endtask

    function automatic string req_of(input logic [3:0] op);
        if (op <= 4'd8)  return "R2";
        if (op == 4'd9)  return "R3";
        if (op <= 4'd12) return "R4";
        return "R5";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 out_valid after reset", 32'(out_valid), 32'd0);
        check("R9 out_mismatch after reset", 32'(out_mismatch), 32'd0);
        rst_n = 1'b1;

        // Table walk, one instruction per cycle (R1)
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R1 out_valid", 32'(out_valid), 32'd1);
                check("R1 tag", 32'(out_tag), 32'(i - 2));
                check(req_of(VEC[i-2][196:193]), out_fix_value, VEC[i-2][32:1]);
                check("R6 mismatch", 32'(out_mismatch), 32'(VEC[i-2][0]));
                check("R7 fix_ok clear fault", 32'(out_fix_ok), 32'd1);
            end
            if (i < NV) drive_vec(i, 1'b0, 1'b0);
            else        idle();
        end

        // R10: bubble gives no output, mismatch stays low
        @(negedge clk);
        check("R10 no output after bubble", 32'(out_valid), 32'd0);
        check("R10 mismatch low when idle", 32'(out_mismatch), 32'd0);

        // R7: other fault marks the correction untrusted
        drive_vec(3, 1'b0, 1'b1);
        @(negedge clk);
        idle();
        @(negedge clk);
        check("R7 fix_ok with other fault", 32'(out_fix_ok), 32'd0);
        check("R6 mismatch with other fault", 32'(out_mismatch), 32'd1);

        // R8: flush drops the staged instruction and the one offered with it
        @(negedge clk);
        drive_vec(0, 1'b0, 1'b0);
        @(negedge clk);
        drive_vec(1, 1'b1, 1'b0);
        @(negedge clk);
        idle();
        check("R8 nothing after flush", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R8 flushed instr absent", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R8 dropped instr absent", 32'(out_valid), 32'd0);

        // R6: fix value carried even when results agree
        drive_vec(12, 1'b0, 1'b0);
        @(negedge clk);
        idle();
        @(negedge clk);
        check("R6 agree mismatch", 32'(out_mismatch), 32'd0);
        check("R4 agree value", out_fix_value, 32'h00000120);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule